// File: doc/BRIEF.md
# Droop-Based Bus Voltage Regulator

This block is the outer, voltage-level control loop of one power converter module that shares a DC bus with other identical modules. Once per switching period, on a strobe taken at the carrier peak, it takes the bus voltage sample and the inductor current sample, estimates how much current the module delivers to the bus, and lowers its own voltage target in proportion to that current. The target follows a two-segment characteristic: a gentle slope while the module is the one holding the bus, and a steep slope once its current passes a knee, where it behaves close to a fixed power source.

A discrete proportional-integral regulator turns the voltage error into the inductor current reference for the inner current loop. That reference is bounded below by zero and above by a programmable ceiling. Because every module gets its own programmable offset on the target, the modules engage one after another as the bus voltage sags. No messages pass between them. A module whose target is below the bus voltage drives its reference to zero and stays idle.

Top module: `droop_bus_regulator`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs and all internal state (captured samples, integrator, configuration words) become zero.
- R2: Outputs change only at an edge where `strobe` is high. `upd_o` is high during exactly the cycle after each such edge. The computation at a strobe uses the samples captured at the previous strobe, and the current inputs are captured for the next one.
- R3: The current estimate `iout_o` is floor(il * (1024 - duty) / 1024) when `boost_mode` is 1, and il itself when `boost_mode` is 0. `duty` is an unsigned fraction of 1024. A negative estimate is reported as 0.
- R4: With slopes sb and sd in volts-LSB per current-LSB with 8 fraction bits and knee current k, the droop term is floor(sb*i/256) for i <= k, and floor((sb*k + sd*(i-k))/256) above it.
- R5: The voltage target `vref_o` equals vset - offset - droop, as a signed value in bus LSBs of 0.1 V.
- R6: The voltage error, target minus bus sample, is saturated to the signed 10-bit range [-512, 511] before it enters the regulator.
- R7: With gains kp and ki in 8 fraction bits and integrator I, the candidate integrator is I + ki*e, and the raw output is u = floor((kp*e + I + ki*e)/256).
- R8: When u < 0, `iref_o` is 0.
- R9: When u exceeds the programmed ceiling imax, `iref_o` equals imax.
- R10: The integrator takes its candidate value except when the output is at the lower clamp with a negative error, or at the upper clamp with a positive error. In those cases it keeps its value.
- R11: A write with `cfg_we` high loads `cfg_wdata` into the word chosen by `cfg_addr`. The addresses are 0 vset, 1 offset, 2 sb, 3 sd, 4 k, 5 imax, 6 kp and 7 ki. vset, offset, k and imax take the low 10 bits, the rest take 16 bits. A write takes effect from the next strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Carrier-peak update pulse, one cycle wide |
| vbus_smp | input | 10 | Bus voltage sample, unsigned, 0.1 V per LSB |
| il_smp | input | 10 | Inductor current sample, signed |
| duty | input | 10 | Duty cycle as unsigned fraction of 1024 |
| boost_mode | input | 1 | 1 selects the boost estimate, 0 the buck estimate |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data |
| iref_o | output | 10 | Inductor current reference for the inner loop |
| vref_o | output | 22 | Droop-adjusted voltage target, signed |
| iout_o | output | 9 | Estimated output current |
| upd_o | output | 1 | High for the cycle after each strobe edge |

## Verification
The hardest condition to reach from the ports is the anti-windup path. The integrator is hidden, so its hold shows only in how fast the reference comes off a clamp once the error changes sign. The stimulus holds the bus at zero for many strobes, which pins the output at the ceiling while the error is positive. It then lifts the bus well above the target, and the bench model predicts the exact recovery sequence. Error saturation is exposed the same way: the bench lowers the proportional gain and raises the ceiling so that the saturated error sets an unclamped output.

// File: rtl/droop_pkg.sv
package droop_pkg;
  localparam int CFG_AW  = 3;
  localparam int CFG_NUM = 1 << CFG_AW;

  typedef enum logic [CFG_AW-1:0] {
    CFG_VSET      = 3'd0,
    CFG_OFFSET    = 3'd1,
    CFG_SLOPE_BUS = 3'd2,
    CFG_SLOPE_DEV = 3'd3,
    CFG_KNEE      = 3'd4,
    CFG_IMAX      = 3'd5,
    CFG_KP        = 3'd6,
    CFG_KI        = 3'd7
  } cfg_idx_e;
endpackage

// File: rtl/dre_cfg_bank.sv
module dre_cfg_bank
  import droop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q [CFG_NUM]
);
  for (genvar g = 0; g < CFG_NUM; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[g] <= '0;
      end else if (we && (addr == CFG_AW'(g))) begin
        word_q[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/dre_iout_est.sv
module dre_iout_est #(
  parameter int IL_W   = 10,
  parameter int DUTY_W = 10,
  localparam int OUT_W = IL_W - 1
) (
  input  logic signed [IL_W-1:0]   il,
  input  logic        [DUTY_W-1:0] duty,
  input  logic                     boost,
  output logic        [OUT_W-1:0]  iout
);
  localparam int PROD_W = IL_W + DUTY_W + 2;
  localparam logic signed [PROD_W-1:0] OUT_MAX = PROD_W'((1 << OUT_W) - 1);

  logic        [DUTY_W:0]   off_frac;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] est;

  always_comb begin
    off_frac = {1'b1, {DUTY_W{1'b0}}} - {1'b0, duty};
    prod     = PROD_W'(il) * $signed(PROD_W'(off_frac));
    est      = boost ? (prod >>> DUTY_W) : PROD_W'(il);
    if (est < 0) begin
      iout = '0;
    end else if (est > OUT_MAX) begin
      iout = '1;
    end else begin
      iout = est[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/dre_droop_ref.sv
module dre_droop_ref #(
  parameter int VB_W   = 10,
  parameter int IOUT_W = 9,
  parameter int KNEE_W = 10,
  parameter int SL_W   = 16,
  parameter int SF     = 8,
  parameter int ERR_W  = 10,
  parameter int VREF_W = 22
) (
  input  logic        [IOUT_W-1:0] iout,
  input  logic        [KNEE_W-1:0] knee,
  input  logic        [SL_W-1:0]   slope_bus,
  input  logic        [SL_W-1:0]   slope_dev,
  input  logic        [VB_W-1:0]   vset,
  input  logic        [VB_W-1:0]   offset,
  input  logic        [VB_W-1:0]   vbus,
  output logic signed [VREF_W-1:0] vref,
  output logic signed [ERR_W-1:0]  err
);
  localparam int PW = SL_W + KNEE_W + 1;
  localparam int EMAX_I = (1 << (ERR_W - 1)) - 1;
  localparam logic signed [VREF_W-1:0] EMAX = VREF_W'(EMAX_I);
  localparam logic signed [VREF_W-1:0] EMIN = -EMAX - 1;

  logic        [PW-1:0]     drop_q;
  logic        [PW-SF-1:0]  drop;
  logic signed [VREF_W-1:0] diff;

  always_comb begin
    if (PW'(iout) <= PW'(knee)) begin
      drop_q = PW'(slope_bus) * PW'(iout);
    end else begin
      drop_q = PW'(slope_bus) * PW'(knee)
             + PW'(slope_dev) * (PW'(iout) - PW'(knee));
    end
    drop = drop_q[PW-1:SF];
    vref = $signed(VREF_W'(vset)) - $signed(VREF_W'(offset))
         - $signed(VREF_W'(drop));
    diff = vref - $signed(VREF_W'(vbus));
    if (diff > EMAX) begin
      err = EMAX[ERR_W-1:0];
    end else if (diff < EMIN) begin
      err = EMIN[ERR_W-1:0];
    end else begin
      err = diff[ERR_W-1:0];
    end
  end
endmodule

// File: rtl/dre_pi.sv
module dre_pi #(
  parameter int ERR_W = 10,
  parameter int GW    = 16,
  parameter int GF    = 8,
  parameter int ACC_W = 40,
  parameter int OUT_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    strobe,
  input  logic signed [ERR_W-1:0] err,
  input  logic        [GW-1:0]    kp,
  input  logic        [GW-1:0]    ki,
  input  logic        [OUT_W-1:0] imax,
  output logic        [OUT_W-1:0] iref
);
  logic signed [ACC_W-1:0] integ_q;
  logic signed [ACC_W-1:0] p_term;
  logic signed [ACC_W-1:0] i_step;
  logic signed [ACC_W-1:0] cand;
  logic signed [ACC_W-1:0] u;
  logic signed [ACC_W-1:0] ceil_s;
  logic                    sat_lo;
  logic                    sat_hi;
  logic                    commit;

  always_comb begin
    p_term = ACC_W'(err) * $signed(ACC_W'(kp));
    i_step = ACC_W'(err) * $signed(ACC_W'(ki));
    cand   = integ_q + i_step;
    u      = (p_term + cand) >>> GF;
    ceil_s = $signed(ACC_W'(imax));
    sat_lo = (u < 0);
    sat_hi = (u > ceil_s);
    commit = !((sat_lo && (err < 0)) || (sat_hi && (err > 0)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      iref    <= '0;
    end else if (strobe) begin
      if (commit) begin
        integ_q <= cand;
      end
      if (sat_lo) begin
        iref <= '0;
      end else if (sat_hi) begin
        iref <= imax;
      end else begin
        iref <= u[OUT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/droop_bus_regulator.sv
module droop_bus_regulator
  import droop_pkg::*;
#(
  parameter int VB_W       = 10,
  parameter int IL_W       = 10,
  parameter int DUTY_W     = 10,
  parameter int CFG_W      = 16,
  parameter int SLOPE_FRAC = 8,
  parameter int GAIN_FRAC  = 8,
  parameter int ERR_W      = 10,
  parameter int ACC_W      = 40,
  localparam int IOUT_W    = IL_W - 1,
  localparam int IREF_W    = IL_W,
  localparam int DROP_PW   = CFG_W + IL_W + 1,
  localparam int VREF_W    = DROP_PW - SLOPE_FRAC + 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     strobe,
  input  logic        [VB_W-1:0]   vbus_smp,
  input  logic signed [IL_W-1:0]   il_smp,
  input  logic        [DUTY_W-1:0] duty,
  input  logic                     boost_mode,
  input  logic                     cfg_we,
  input  logic        [CFG_AW-1:0] cfg_addr,
  input  logic        [CFG_W-1:0]  cfg_wdata,
  output logic        [IREF_W-1:0] iref_o,
  output logic signed [VREF_W-1:0] vref_o,
  output logic        [IOUT_W-1:0] iout_o,
  output logic                     upd_o
);
  logic        [CFG_W-1:0]  cfg_q [CFG_NUM];
  logic        [VB_W-1:0]   hold_vb;
  logic signed [IL_W-1:0]   hold_il;
  logic        [DUTY_W-1:0] hold_duty;
  logic                     hold_boost;
  logic        [IOUT_W-1:0] iout_c;
  logic signed [VREF_W-1:0] vref_c;
  logic signed [ERR_W-1:0]  err_c;
  logic        [IREF_W-1:0] imax_c;

  assign imax_c = cfg_q[int'(CFG_IMAX)][IREF_W-1:0];

  dre_cfg_bank #(.DATA_W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .word_q(cfg_q)
  );

  // samples taken at this strobe are consumed at the next one
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vb    <= '0;
      hold_il    <= '0;
      hold_duty  <= '0;
      hold_boost <= 1'b0;
    end else if (strobe) begin
      hold_vb    <= vbus_smp;
      hold_il    <= il_smp;
      hold_duty  <= duty;
      hold_boost <= boost_mode;
    end
  end

  dre_iout_est #(.IL_W(IL_W), .DUTY_W(DUTY_W)) u_est (
    .il   (hold_il),
    .duty (hold_duty),
    .boost(hold_boost),
    .iout (iout_c)
  );

  dre_droop_ref #(
    .VB_W  (VB_W),
    .IOUT_W(IOUT_W),
    .KNEE_W(IL_W),
    .SL_W  (CFG_W),
    .SF    (SLOPE_FRAC),
    .ERR_W (ERR_W),
    .VREF_W(VREF_W)
  ) u_ref (
    .iout     (iout_c),
    .knee     (cfg_q[int'(CFG_KNEE)][IL_W-1:0]),
    .slope_bus(cfg_q[int'(CFG_SLOPE_BUS)]),
    .slope_dev(cfg_q[int'(CFG_SLOPE_DEV)]),
    .vset     (cfg_q[int'(CFG_VSET)][VB_W-1:0]),
    .offset   (cfg_q[int'(CFG_OFFSET)][VB_W-1:0]),
    .vbus     (hold_vb),
    .vref     (vref_c),
    .err      (err_c)
  );

  dre_pi #(
    .ERR_W(ERR_W),
    .GW   (CFG_W),
    .GF   (GAIN_FRAC),
    .ACC_W(ACC_W),
    .OUT_W(IREF_W)
  ) u_pi (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .err   (err_c),
    .kp    (cfg_q[int'(CFG_KP)]),
    .ki    (cfg_q[int'(CFG_KI)]),
    .imax  (imax_c),
    .iref  (iref_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vref_o <= '0;
      iout_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= strobe;
      if (strobe) begin
        vref_o <= vref_c;
        iout_o <= iout_c;
      end
    end
  end
endmodule

// File: rtl/dre_checker.sv
module dre_checker #(
  parameter int IL_W   = 10,
  parameter int IREF_W = 10,
  parameter int IOUT_W = 9
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     strobe,
  input logic                     upd_o,
  input logic        [IREF_W-1:0] iref_o,
  input logic        [IREF_W-1:0] imax_c,
  input logic signed [IL_W-1:0]   hold_il,
  input logic                     hold_boost,
  input logic        [IOUT_W-1:0] iout_o
);
  // R2: update flag follows the strobe by one cycle
  p_upd_follows_r2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> upd_o);

  // R2: no strobe means no flag and no change of the reference
  p_quiet_gap_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (!upd_o && $stable(iref_o)));

  // R9: the reference never exceeds the ceiling in force at the update
  p_ceiling_r9: assert property (@(posedge clk) disable iff (rst)
    upd_o |-> (iref_o <= $past(imax_c)));

  // R3: buck estimate passes a non-negative current straight through
  p_buck_copy_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe && !hold_boost && !hold_il[IL_W-1])
      |=> (iout_o == $past(hold_il[IOUT_W-1:0])));

  // R3: a negative inductor current yields a zero estimate in either mode
  p_neg_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe && hold_il[IL_W-1]) |=> (iout_o == '0));
endmodule

bind droop_bus_regulator dre_checker #(
  .IL_W  (IL_W),
  .IREF_W(IREF_W),
  .IOUT_W(IOUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strobe    (strobe),
  .upd_o     (upd_o),
  .iref_o    (iref_o),
  .imax_c    (imax_c),
  .hold_il   (hold_il),
  .hold_boost(hold_boost),
  .iout_o    (iout_o)
);

// File: tb/droop_bus_regulator_bench.sv
module droop_bus_regulator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               strobe = 1'b0;
  logic [9:0]         vbus_smp = '0;
  logic signed [9:0]  il_smp = '0;
  logic [9:0]         duty = '0;
  logic               boost_mode = 1'b0;
  logic               cfg_we = 1'b0;
  logic [2:0]         cfg_addr = '0;
  logic [15:0]        cfg_wdata = '0;
  logic [9:0]         iref_o;
  logic signed [21:0] vref_o;
  logic [8:0]         iout_o;
  logic               upd_o;

  droop_bus_regulator u_droop_bus_regulator (
    .clk(clk), .rst(rst), .strobe(strobe), .vbus_smp(vbus_smp),
    .il_smp(il_smp), .duty(duty), .boost_mode(boost_mode),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .iref_o(iref_o), .vref_o(vref_o), .iout_o(iout_o), .upd_o(upd_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  // behavioural reference state
  longint m_cfg [8];
  longint m_hvb, m_hil, m_hduty, m_integ, m_iref, m_vref, m_iout;
  bit     m_hboost, m_upd;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    longint io, dq, drop, vref, e, cand, u, sb, sd, kn, im;
    bit commit;
    if (rst) begin
      foreach (m_cfg[i]) m_cfg[i] = 0;
      m_hvb = 0; m_hil = 0; m_hduty = 0; m_hboost = 0;
      m_integ = 0; m_iref = 0; m_vref = 0; m_iout = 0; m_upd = 0;
      return;
    end
    m_upd = strobe;
    if (strobe) begin
      io = m_hboost ? ((m_hil * (1024 - m_hduty)) >>> 10) : m_hil;
      if (io < 0) io = 0;
      sb = m_cfg[2]; sd = m_cfg[3]; kn = m_cfg[4]; im = m_cfg[5];
      dq = (io <= kn) ? sb * io : sb * kn + sd * (io - kn);
      drop = dq >>> 8;
      vref = m_cfg[0] - m_cfg[1] - drop;
      e = vref - m_hvb;
      if (e > 511) e = 511;
      if (e < -512) e = -512;
      cand = m_integ + m_cfg[7] * e;
      u = (m_cfg[6] * e + cand) >>> 8;
      if (u < 0) begin
        m_iref = 0; commit = (e >= 0);
      end else if (u > im) begin
        m_iref = im; commit = (e <= 0);
      end else begin
        m_iref = u; commit = 1;
      end
      if (commit) m_integ = cand;
      m_vref = vref; m_iout = io;
      m_hvb = vbus_smp; m_hil = il_smp; m_hduty = duty; m_hboost = boost_mode;
    end
    if (cfg_we) begin
      case (cfg_addr)
        3'd0, 3'd1, 3'd4, 3'd5: m_cfg[cfg_addr] = cfg_wdata & 16'h03FF;
        default:                m_cfg[cfg_addr] = cfg_wdata;
      endcase
    end
  endtask

  task automatic compare();
    chk({cur_req, "/R7"}, "iref_o", iref_o, m_iref);
    chk({cur_req, "/R5"}, "vref_o", vref_o, m_vref);
    chk({cur_req, "/R3"}, "iout_o", iout_o, m_iout);
    chk({cur_req, "/R2"}, "upd_o", upd_o, m_upd);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic cfg_write(int a, int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic pulses(int n, int gap);
    for (int i = 0; i < n; i++) begin
      strobe = 1'b1;
      tick();
      strobe = 1'b0;
      for (int j = 0; j < gap; j++) tick();
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=%0d expected=0", WATCHDOG);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) tick();
    chk("R1", "iref_o after reset", iref_o, 0);
    chk("R1", "vref_o after reset", vref_o, 0);
    rst = 1'b0;
    tick();

    cur_req = "R11";
    cfg_write(0, 16'hF258);   // vset 600, upper bits dropped
    cfg_write(1, 20);         // 2 V offset
    cfg_write(2, 64);
    cfg_write(3, 768);
    cfg_write(4, 100);
    cfg_write(5, 400);
    cfg_write(6, 512);
    cfg_write(7, 64);
    pulses(2, 3);
    chk("R11", "vref_o with vset 600 offset 20", vref_o, 580);

    cur_req = "R7";
    boost_mode = 1'b1; duty = 300; il_smp = 50; vbus_smp = 575;
    pulses(20, 3);

    cur_req = "R4";
    il_smp = 300; vbus_smp = 540; duty = 0;
    pulses(20, 3);

    cur_req = "R3";
    boost_mode = 1'b0; il_smp = 200;
    pulses(6, 2);
    chk("R3", "buck estimate", iout_o, 200);
    il_smp = -100;
    pulses(6, 2);
    chk("R3", "negative current estimate", iout_o, 0);

    cur_req = "R5";
    cfg_write(1, 40);
    il_smp = 80; boost_mode = 1'b1; duty = 512;
    pulses(10, 3);

    cur_req = "R2";
    pulses(10, 0);
    vbus_smp = 560;
    pulses(4, 15);

    cur_req = "R8";
    vbus_smp = 900;
    pulses(20, 2);
    chk("R8", "iref_o with bus above target", iref_o, 0);

    cur_req = "R9";
    vbus_smp = 0; il_smp = 0;
    pulses(30, 2);
    chk("R9", "iref_o at ceiling", iref_o, 400);

    cur_req = "R10";
    vbus_smp = 700;
    pulses(3, 2);
    checks++;
    if (iref_o >= 400) begin
      errors++;
      $display("FAIL R10 recovery actual=%0d expected=<400", iref_o);
    end
    pulses(10, 2);

    cur_req = "R6";
    cfg_write(5, 1023);
    cfg_write(6, 128);
    cfg_write(7, 0);
    vbus_smp = 0; il_smp = 0;
    pulses(8, 2);
    cfg_write(3, 16'hFFFF);
    il_smp = 500; boost_mode = 1'b0; vbus_smp = 100;
    pulses(8, 2);

    cur_req = "R7";
    cfg_write(3, 768); cfg_write(5, 400); cfg_write(6, 512); cfg_write(7, 64);
    for (int k = 0; k < 300; k++) begin
      vbus_smp   = 10'($urandom_range(450, 650));
      il_smp     = 10'($signed($urandom_range(0, 700)) - 150);
      duty       = 10'($urandom_range(0, 1023));
      boost_mode = 1'($urandom_range(0, 1));
      pulses(1, int'($urandom_range(0, 4)));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule